// File: doc/BRIEF.md
# Wakeup Boot Vector Selector

After a deep-sleep wakeup, this block decides where the waking CPU starts to fetch. Each CPU has its own select bit. When the waking CPU's bit is clear, the block hands out the slow retention memory address `0x50000000` at once. When the bit is set, the block reads the fast retention memory one 32-bit word per cycle through a read port and computes a CRC-32 over the words. It compares the result with a stored checksum word. On a match the CPU is sent to a stored entry address. On any mismatch, or when the configured length is too large, the CPU takes the normal boot address `0x40000400`.

The block's outputs are a 32-bit boot vector and a `boot_go` level. `boot_go` is raised only after the vector is final. The vector and `boot_go` then hold until the next wakeup pulse.

Top module: `wake_vector_sel`

## Requirements
- R1: While reset is held, and after it is released with no wakeup pulse, `boot_vec` is `0x40000400` and `boot_go` is 0.
- R2: A `wake` pulse for a CPU whose select bit is 0 makes `boot_vec` `0x50000000` and `boot_go` 1 one cycle after the edge that samples the pulse.
- R3: The select bit used is `vsel[cpu_sel]`, where bit 0 belongs to CPU 0 and bit 1 belongs to CPU 1.
- R4: With the select bit at 1 and `word_cnt` N in the range 1..2048, the block drives `mem_rd` high and `mem_addr` through 0..N-1, one address per cycle, starting the cycle after the wake edge. `mem_rdata` is read in the same cycle as its address. `boot_go` rises N cycles after the wake edge.
- R5: The checksum is the reflected CRC-32 (polynomial 0x04C11DB7, initial value and final XOR 0xFFFFFFFF) over the words. Each word is fed as four bytes, least significant byte first. When the checksum equals `crc_store`, the final vector is `entry_store`.
- R6: When the checksum differs from `crc_store`, the final vector is `0x40000400`.
- R7: While a scan runs, `boot_go` is 0 and `boot_vec` is `0x40000400`.
- R8: A `word_cnt` above 2048 counts as a mismatch, and the result is given one cycle after the wake edge. A `word_cnt` of 0 gives a checksum of `0x00000000`, also one cycle after the wake edge.
- R9: A `wake` pulse that arrives during a scan has no effect.
- R10: Once `boot_go` is 1, it and `boot_vec` hold until the next `wake` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wake | input | 1 | Wakeup pulse |
| cpu_sel | input | 1 | Index of the waking CPU |
| vsel | input | 2 | Per-CPU vector-select bits |
| crc_store | input | 32 | Stored checksum word |
| entry_store | input | 32 | Stored entry address word |
| word_cnt | input | 13 | Number of retention words to check |
| mem_rd | output | 1 | Retention memory read strobe |
| mem_addr | output | 11 | Retention memory word address |
| mem_rdata | input | 32 | Retention memory read data, same cycle |
| boot_vec | output | 32 | Reset vector for the waking CPU |
| boot_go | output | 1 | Vector is final, CPU may start |

## Verification
The direct path, and the paths for a zero-length or oversized count, settle one cycle after the edge that samples `wake`. A checksum scan of N words settles N cycles after that edge, and its read address advances once per cycle from the first cycle after the edge. The bench model holds a count of remaining scan cycles, taken from the requirements. Each posedge of the model marks the same edge as the design. At every falling edge the bench compares `boot_vec`, `boot_go` and, during scans, `mem_addr`. Scans of lengths 1, 16 and 2048, a wakeup inside a scan, and the idle hold are each compared at those exact cycles.

// File: rtl/wake_vector_sel.sv
module wake_vector_sel #(
  parameter int MAX_WORDS = 2048,
  parameter int NCPU = 2,
  parameter logic [31:0] NORMAL_VEC = 32'h4000_0400,
  parameter logic [31:0] SLOW_VEC = 32'h5000_0000,
  localparam int AW = $clog2(MAX_WORDS),
  localparam int CW = AW + 2,
  localparam int PW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wake,
  input  logic [PW-1:0] cpu_sel,
  input  logic [NCPU-1:0] vsel,
  input  logic [31:0]   crc_store,
  input  logic [31:0]   entry_store,
  input  logic [CW-1:0] word_cnt,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [31:0]   mem_rdata,
  output logic [31:0]   boot_vec,
  output logic          boot_go
);

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_DONE} st_t;

  st_t st;
  logic [CW-1:0] idx, cnt_q;
  logic [31:0] crc;
  logic [31:0] crc_next, crc_fin;
  logic last;

  function automatic logic [31:0] crc_word(input logic [31:0] c, input logic [31:0] w);
    logic [31:0] r;
    r = c ^ w;
    for (int i = 0; i < 32; i++)
      r = r[0] ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
    return r;
  endfunction

  assign crc_next = crc_word(crc, mem_rdata);
  assign crc_fin  = ~crc_next;
  assign last     = (idx == cnt_q - CW'(1));
  assign mem_rd   = (st == ST_SCAN);
  assign mem_addr = idx[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      idx      <= '0;
      cnt_q    <= '0;
      crc      <= 32'hFFFF_FFFF;
      boot_vec <= NORMAL_VEC;
      boot_go  <= 1'b0;
    end else if (st == ST_SCAN) begin
      crc <= crc_next;
      idx <= idx + CW'(1);
      if (last) begin
        st       <= ST_DONE;
        boot_go  <= 1'b1;
        boot_vec <= (crc_fin == crc_store) ? entry_store : NORMAL_VEC;
      end
    end else if (wake) begin
      if (!vsel[cpu_sel]) begin
        st       <= ST_DONE;
        boot_go  <= 1'b1;
        boot_vec <= SLOW_VEC;
      end else if (word_cnt == '0) begin
        st       <= ST_DONE;
        boot_go  <= 1'b1;
        boot_vec <= (crc_store == 32'h0) ? entry_store : NORMAL_VEC;
      end else if (word_cnt > CW'(MAX_WORDS)) begin
        st       <= ST_DONE;
        boot_go  <= 1'b1;
        boot_vec <= NORMAL_VEC;
      end else begin
        st       <= ST_SCAN;
        idx      <= '0;
        cnt_q    <= word_cnt;
        crc      <= 32'hFFFF_FFFF;
        boot_go  <= 1'b0;
        boot_vec <= NORMAL_VEC;
      end
    end
  end

endmodule

// File: rtl/wake_vector_sel_chk.sv
module wake_vector_sel_chk #(
  parameter int MAX_WORDS = 2048,
  parameter int NCPU = 2,
  parameter int CW = 13,
  parameter int PW = 1,
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wake,
  input logic [PW-1:0] cpu_sel,
  input logic [NCPU-1:0] vsel,
  input logic [CW-1:0] word_cnt,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   boot_vec,
  input logic          boot_go
);

  // R7
  scan_holds_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (!boot_go && boot_vec == 32'h4000_0400));

  // R2
  slow_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !mem_rd && !vsel[cpu_sel]) |=> (boot_go && boot_vec == 32'h5000_0000));

  // R8
  oversize_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !mem_rd && vsel[cpu_sel] && word_cnt > CW'(MAX_WORDS))
      |=> (boot_go && boot_vec == 32'h4000_0400));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_go && !wake) |=> (boot_go && $stable(boot_vec)));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

endmodule

bind wake_vector_sel wake_vector_sel_chk #(
  .MAX_WORDS(MAX_WORDS), .NCPU(NCPU), .CW(CW), .PW(PW), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wake(wake), .cpu_sel(cpu_sel), .vsel(vsel),
  .word_cnt(word_cnt), .mem_rd(mem_rd), .mem_addr(mem_addr),
  .boot_vec(boot_vec), .boot_go(boot_go)
);

// File: tb/sim_wake_vector_sel.sv
module sim_wake_vector_sel;
  localparam int MAXW = 2048;
  localparam logic [31:0] NORM = 32'h4000_0400;
  localparam logic [31:0] SLOW = 32'h5000_0000;

  logic clk = 0, rst_n = 0, wake = 0, cpu_sel = 0;
  logic [1:0] vsel = 2'b00;
  logic [31:0] crc_store = 0, entry_store = 32'h5000_0100;
  logic [12:0] word_cnt = 0;
  logic mem_rd;
  logic [10:0] mem_addr;
  logic [31:0] mem_rdata, boot_vec;
  logic boot_go;
  logic [31:0] mem [MAXW];

  always #5 clk = ~clk;
  assign mem_rdata = mem[mem_addr];

  wake_vector_sel u0 (.*);

  int nvec = 0, nbad = 0, cyc = 0;
  string req = "R1";

  function automatic logic [31:0] ref_crc(int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int w = 0; w < n; w++)
      for (int b = 0; b < 4; b++) begin
        c ^= {24'h0, mem[w][8*b +: 8]};
        for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
      end
    return ~c;
  endfunction

  // behavioural reference
  logic [31:0] e_vec = NORM, e_fin;
  logic e_go = 0, m_busy = 0;
  int m_left = 0, m_n = 0;
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      e_vec = NORM; e_go = 0; m_busy = 0;
    end else if (m_busy) begin
      m_left--;
      if (m_left == 0) begin m_busy = 0; e_go = 1; e_vec = e_fin; end
    end else if (wake) begin
      if (!vsel[cpu_sel]) begin e_go = 1; e_vec = SLOW; end
      else if (word_cnt > MAXW) begin e_go = 1; e_vec = NORM; end
      else begin
        e_fin = (ref_crc(int'(word_cnt)) == crc_store) ? entry_store : NORM;
        if (word_cnt == 0) begin e_go = 1; e_vec = e_fin; end
        else begin
          m_busy = 1; m_n = int'(word_cnt); m_left = m_n; e_go = 0; e_vec = NORM;
        end
      end
    end
  end

  always @(negedge clk) begin
    nvec++;
    if (boot_vec !== e_vec || boot_go !== e_go) begin
      nbad++;
      $display("FAIL %s vec=%h go=%b expected vec=%h go=%b", req, boot_vec, boot_go, e_vec, e_go);
    end
    if (m_busy) begin
      nvec++;
      if (mem_rd !== 1'b1 || mem_addr !== 11'(m_n - m_left)) begin
        nbad++;
        $display("FAIL R4 rd=%b addr=%0d expected rd=1 addr=%0d", mem_rd, mem_addr, m_n - m_left);
      end
    end
  end

  task automatic pulse();
    @(negedge clk); wake = 1;
    @(negedge clk); wake = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < MAXW; i++) mem[i] = (i * 32'h9E37_79B9) ^ 32'h1234_5678;
    req = "R1"; idle(3); rst_n = 1; idle(3);
    req = "R2"; vsel = 2'b10; cpu_sel = 0; pulse(); idle(3);
    req = "R10"; idle(5);
    req = "R3"; cpu_sel = 1; word_cnt = 16; crc_store = ref_crc(16); pulse(); idle(20);
    req = "R3"; vsel = 2'b01; pulse(); idle(3);
    req = "R5"; vsel = 2'b11; cpu_sel = 0; word_cnt = 1; crc_store = ref_crc(1);
    entry_store = 32'h5000_0200; pulse(); idle(4);
    req = "R6"; word_cnt = 16; crc_store = ref_crc(16) ^ 32'h1; pulse(); idle(20);
    req = "R7"; word_cnt = 2048; crc_store = ref_crc(2048); entry_store = 32'h5000_0300;
    pulse(); idle(100);
    req = "R9"; pulse(); idle(2000);
    req = "R8"; word_cnt = 2049; pulse(); idle(3);
    req = "R8"; word_cnt = 0; crc_store = 32'h0; entry_store = 32'h5000_0400; pulse(); idle(3);
    req = "R8"; crc_store = 32'h5; pulse(); idle(3);
    req = "R10"; idle(10);
    req = "R1"; rst_n = 0; idle(2); rst_n = 1; idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    nbad++;
    $display("FAIL watchdog %s cycles=%0d expected below 100000", req, cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule